// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block is a bus-master sequencer that carries one byte, word or long-word operand across a 16-bit external data bus whose slaves may be either 16 or 8 bits wide. An internal requester hands over an address, a size code, a direction and (for writes) the operand. The block then runs as many bus cycles as the slave's port width demands. On every cycle it drives an address, a size code giving the bytes still outstanding, and the data lanes. It waits for one of two active-low acknowledge lines. The line that answers tells the master how wide the port is.

An acknowledge from an 8-bit port moves one byte on the upper lane. The master then lowers its remaining-byte count by one, advances the address by one and opens the next cycle. An acknowledge from a 16-bit port at an even address, with two or more bytes left, moves two bytes at once. Read bytes arrive most significant first and are shifted into an operand register. The register is right-justified, so a word or byte result appears in the low bits with zeros above. A one-cycle done pulse presents the result after the last acknowledge.

Top module: `dsz_master`

## Requirements
- R1: After reset the block is idle: reqReady is 1, busActive is 0 and done is 0.
- R2: busSize gives the bytes still to move as 00 = four, 11 = three, 10 = two, 01 = one; reqSize uses the same code (01 byte, 10 word, 00 long word).
- R3: A word at an even address to a 16-bit port completes in one bus cycle with busSize 10, busAddr bit 0 equal to 0, and all 16 data bits carried.
- R4: An acknowledge with ackNarrowN low and ackWideN high (8-bit port) lowers the count by one and raises busAddr by one, and a new cycle follows until no bytes remain; a long word takes four cycles with sizes 00, 11, 10, 01 and address bit 0 going 0, 1, 0, 1.
- R5: On an 8-bit port read only busDin[15:8] is taken and busDin[7:0] is ignored; bytes are assembled most significant first into rdData, right-justified with zeros above.
- R6: On writes, busDout[15:8] carries the next operand byte; busDout[7:0] carries the byte after it when busAddr is even and two or more bytes remain, and otherwise a copy of the upper byte.
- R7: ackWideN low (16-bit port, taking precedence over ackNarrowN) at an even address with two or more bytes left moves two bytes: the count drops by two and the address rises by two, so a long word takes two cycles with sizes 00 then 10.
- R8: A single byte moved on a 16-bit port uses the lower lane (bits 7:0) at an odd address and the upper lane at an even address.
- R9: While both acknowledge lines are high, the active cycle holds busAddr, busSize, busWrite and busDout unchanged.
- R10: done is high for exactly one cycle, the cycle after the clock edge that samples the final acknowledge, and rdData holds the assembled operand while done is high.
- R11: A request is taken only while reqReady is high; reqValid during an operation has no effect on the bus or on the operand.
- R12: reqReady is low for as long as a bus operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken while reqReady is high |
| reqReady | output | 1 | Block idle and able to take a request |
| reqAddr | input | ADDR_W | Operand start address |
| reqSize | input | 2 | Operand size code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 4*BYTE_W | Write operand, right-justified |
| busActive | output | 1 | A bus cycle is in progress |
| busAddr | output | ADDR_W | Bus cycle address |
| busSize | output | 2 | Bytes still to move, coded |
| busWrite | output | 1 | Direction of the bus cycle |
| busDout | output | 2*BYTE_W | Write data lanes |
| busDin | input | 2*BYTE_W | Read data lanes |
| ackWideN | input | 1 | Active-low acknowledge from a 16-bit port |
| ackNarrowN | input | 1 | Active-low acknowledge from an 8-bit port |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 4*BYTE_W | Assembled read operand |

## Verification
On every cycle the assertions check several bus rules. A waiting cycle must hold its address, size, direction and data. A narrow acknowledge must step the count and address by one, and a wide acknowledge on a long word by two. Lanes at an odd address must carry copies of one byte. A done pulse must follow a sampled acknowledge, last one cycle, and an accepted request must open a bus cycle. Only the bench scenarios show the full size and address sequences of each operand and port width. The same holds for the right-justified byte order of read results, the ignored lower lane on narrow reads, the lane used for odd bytes on a wide port, and the fact that a request made while busy has no effect.

// File: rtl/dsz_pkg.sv
package dsz_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic stepOne;  // one byte moved
    logic stepTwo;  // two bytes moved
    logic lowLane;  // single byte sits on the lower lane
    logic finish;   // last acknowledge of the operand
  } strobeT;

  // size code to byte count: 00 means four
  function automatic logic [2:0] sizeToBytes(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction

endpackage

// File: rtl/dsz_ctrl.sv
module dsz_ctrl
  import dsz_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       ackWideN,
  input  logic       ackNarrowN,
  input  logic [2:0] bytesLeft,
  input  logic       addrOdd,
  output logic       busy,
  output strobeT     strb
);

  stateT stateQ;
  stateT stateD;
  logic  ackAny;
  logic  wide;
  logic  pair;

  always_comb begin
    ackAny = (stateQ == ST_BUS) && (!ackWideN || !ackNarrowN);
    wide   = !ackWideN;
    pair   = wide && (bytesLeft >= 3'd2) && !addrOdd;

    strb.load    = (stateQ == ST_IDLE) && reqValid;
    strb.stepTwo = ackAny && pair;
    strb.stepOne = ackAny && !pair;
    strb.lowLane = wide && addrOdd;
    strb.finish  = ackAny && (bytesLeft == (pair ? 3'd2 : 3'd1));

    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (strb.load)   stateD = ST_BUS;
      ST_BUS:  if (strb.finish) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_BUS);

endmodule

// File: rtl/dsz_dpath.sv
module dsz_dpath
  import dsz_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic                  reqWrite,
  input  logic [4*BYTE_W-1:0]   reqWdata,
  input  logic [2*BYTE_W-1:0]   busDin,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [1:0]            busSize,
  output logic                  busWrite,
  output logic [2*BYTE_W-1:0]   busDout,
  output logic [2:0]            bytesLeft,
  output logic                  addrOdd,
  output logic                  done,
  output logic [4*BYTE_W-1:0]   rdData
);

  localparam int BUS_W = 2 * BYTE_W;
  localparam int OP_W  = 4 * BYTE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [2:0]        bytesQ;
  logic              writeQ;
  logic [OP_W-1:0]   shQ;     // write operand, next byte at the top
  logic [OP_W-1:0]   rdQ;     // read operand, shifted in from the bottom
  logic              doneQ;

  logic [2:0]        loadBytes;
  logic [OP_W-1:0]   shLoad;
  logic [BYTE_W-1:0] pickByte;
  logic [BYTE_W-1:0] hiByte;
  logic [BYTE_W-1:0] nextByte;

  always_comb begin
    loadBytes = sizeToBytes(reqSize);
    shLoad    = reqWdata << (BYTE_W * (4 - int'(loadBytes)));
    pickByte  = strb.lowLane ? busDin[BYTE_W-1:0] : busDin[BUS_W-1:BYTE_W];
    hiByte    = shQ[OP_W-1 -: BYTE_W];
    nextByte  = shQ[OP_W-BYTE_W-1 -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      bytesQ <= '0;
      writeQ <= 1'b0;
      shQ    <= '0;
      rdQ    <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.finish;
      if (strb.load) begin
        addrQ  <= reqAddr;
        bytesQ <= loadBytes;
        writeQ <= reqWrite;
        shQ    <= shLoad;
        rdQ    <= '0;
      end else if (strb.stepTwo) begin
        addrQ  <= addrQ + ADDR_W'(2);
        bytesQ <= bytesQ - 3'd2;
        shQ    <= shQ << BUS_W;
        rdQ    <= {rdQ[OP_W-BUS_W-1:0], busDin};
      end else if (strb.stepOne) begin
        addrQ  <= addrQ + ADDR_W'(1);
        bytesQ <= bytesQ - 3'd1;
        shQ    <= shQ << BYTE_W;
        rdQ    <= {rdQ[OP_W-BYTE_W-1:0], pickByte};
      end
    end
  end

  always_comb begin
    busAddr   = addrQ;
    busSize   = bytesQ[1:0];
    busWrite  = writeQ;
    busDout[BUS_W-1:BYTE_W] = hiByte;
    busDout[BYTE_W-1:0]     = (!addrQ[0] && (bytesQ >= 3'd2)) ? nextByte : hiByte;
    bytesLeft = bytesQ;
    addrOdd   = addrQ[0];
    done      = doneQ;
    rdData    = rdQ;
  end

endmodule

// File: rtl/dsz_master.sv
module dsz_master
  import dsz_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic                  reqWrite,
  input  logic [4*BYTE_W-1:0]   reqWdata,
  output logic                  busActive,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [1:0]            busSize,
  output logic                  busWrite,
  output logic [2*BYTE_W-1:0]   busDout,
  input  logic [2*BYTE_W-1:0]   busDin,
  input  logic                  ackWideN,
  input  logic                  ackNarrowN,
  output logic                  done,
  output logic [4*BYTE_W-1:0]   rdData
);

  strobeT     strb;
  logic       busy;
  logic [2:0] bytesLeft;
  logic       addrOdd;

  dsz_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .ackWideN   (ackWideN),
    .ackNarrowN (ackNarrowN),
    .bytesLeft  (bytesLeft),
    .addrOdd    (addrOdd),
    .busy       (busy),
    .strb       (strb)
  );

  dsz_dpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .busDin    (busDin),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busWrite  (busWrite),
    .busDout   (busDout),
    .bytesLeft (bytesLeft),
    .addrOdd   (addrOdd),
    .done      (done),
    .rdData    (rdData)
  );

  assign busActive = busy;
  assign reqReady  = !busy;

endmodule

// File: rtl/dsz_master_chk.sv
module dsz_master_chk #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic                busActive,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [1:0]          busSize,
  input logic                busWrite,
  input logic [2*BYTE_W-1:0] busDout,
  input logic                ackWideN,
  input logic                ackNarrowN,
  input logic                done
);

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busActive && ackWideN && ackNarrowN |=> busActive && $stable(busAddr) && $stable(busSize) && $stable(busWrite) && $stable(busDout)); // R9

  AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busActive && ackWideN && !ackNarrowN && busSize != 2'b01 |=> busActive && busSize == $past(busSize) - 2'd1 && busAddr == $past(busAddr) + ADDR_W'(1)); // R4

  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busActive && !ackWideN && !busAddr[0] && busSize == 2'b00 |=> busActive && busSize == 2'b10 && busAddr == $past(busAddr) + ADDR_W'(2)); // R7

  AST_ODD_COPY: assert property (@(posedge clk) disable iff (!rstN)
    busActive && busWrite && busAddr[0] |-> busDout[2*BYTE_W-1:BYTE_W] == busDout[BYTE_W-1:0]); // R6

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busActive && (!ackWideN || !ackNarrowN)) && !busActive); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_REQ_START: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> busActive && !reqReady); // R11

endmodule

bind dsz_master dsz_master_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/dsz_master_tb_top.sv
`timescale 1ns/1ps
module dsz_master_tb_top;

  localparam int ADDR_W = 24;
  localparam int BYTE_W = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'b00;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        busActive;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0]  busSize;
  logic        busWrite;
  logic [15:0] busDout;
  logic [15:0] busDin = 16'hDEAD;
  logic        ackWideN = 1'b1;
  logic        ackNarrowN = 1'b1;
  logic        done;
  logic [31:0] rdData;

  dsz_master #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dut_i (.*);

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycle = 0;

  // slave model
  logic [7:0]  mem [0:255];
  bit          portWide = 1'b0;
  int          waitCycles = 0;
  int          waitCnt = 0;
  int          logCnt = 0;
  int          lastAckCycle = 0;
  logic [ADDR_W-1:0] logAddr [0:15];
  logic [1:0]  logSize [0:15];
  logic [15:0] logDout [0:15];

  always @(posedge clk) cycle++;

  always @(negedge clk) begin
    int rem;
    logic [7:0] a;
    ackWideN   = 1'b1;
    ackNarrowN = 1'b1;
    busDin     = 16'hDEAD;
    if (rstN && busActive) begin
      if (waitCnt < waitCycles) begin
        waitCnt++;
      end else begin
        waitCnt = 0;
        if (logCnt < 16) begin
          logAddr[logCnt] = busAddr;
          logSize[logCnt] = busSize;
          logDout[logCnt] = busDout;
        end
        logCnt++;
        lastAckCycle = cycle;
        rem = (busSize == 2'b00) ? 4 : int'(busSize);
        a = busAddr[7:0];
        if (portWide) begin
          ackWideN = 1'b0;
          if (busWrite) begin
            if (!a[0] && rem >= 2) begin
              mem[a] = busDout[15:8];
              mem[a + 8'd1] = busDout[7:0];
            end else if (a[0]) mem[a] = busDout[7:0];
            else mem[a] = busDout[15:8];
          end else begin
            busDin = {mem[{a[7:1], 1'b0}], mem[{a[7:1], 1'b1}]};
          end
        end else begin
          ackNarrowN = 1'b0;
          if (busWrite) mem[a] = busDout[15:8];
          else busDin = {mem[a], 8'h5A};
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic startReq(input logic [ADDR_W-1:0] addr, input logic [1:0] sz, input bit wr,
                          input logic [31:0] wd, input bit wide, input int waits);
    portWide = wide;
    waitCycles = waits;
    waitCnt = 0;
    logCnt = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = sz; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output logic [31:0] rd);
    int doneC;
    doneC = -1;
    rd = 'x;
    for (int i = 0; i < 300; i++) begin
      if (done) begin
        doneC = cycle;
        rd = rdData;
        break;
      end
      @(negedge clk);
    end
    chk("R10", "done follows final ack by one cycle", 32'(doneC), 32'(lastAckCycle + 1));
    @(negedge clk);
    chk("R10", "done lasts one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic runOp(input logic [ADDR_W-1:0] addr, input logic [1:0] sz, input bit wr,
                       input logic [31:0] wd, input bit wide, input int waits, output logic [31:0] rd);
    startReq(addr, sz, wr, wd, wide, waits);
    waitDone(rd);
  endtask

  task automatic testReset();
    chk("R1", "reqReady after reset", {31'd0, reqReady}, 32'd1);
    chk("R1", "busActive after reset", {31'd0, busActive}, 32'd0);
    chk("R1", "done after reset", {31'd0, done}, 32'd0);
  endtask

  task automatic testWordWide();
    logic [31:0] rd, exp;
    exp = {16'h0, mem[8'h10], mem[8'h11]};
    runOp(24'h000010, 2'b10, 1'b0, '0, 1'b1, 0, rd);
    chk("R3", "word wide cycles", 32'(logCnt), 32'd1);
    chk("R3", "word wide size", {30'd0, logSize[0]}, 32'h2);
    chk("R3", "word wide addr bit0", {31'd0, logAddr[0][0]}, 32'd0);
    chk("R3", "word wide data", rd, exp);
  endtask

  task automatic testLongNarrowRead();
    logic [31:0] rd, exp;
    exp = {mem[8'h20], mem[8'h21], mem[8'h22], mem[8'h23]};
    runOp(24'h000020, 2'b00, 1'b0, '0, 1'b0, 1, rd);
    chk("R4", "long narrow cycles", 32'(logCnt), 32'd4);
    chk("R2", "size sequence", {24'd0, logSize[0], logSize[1], logSize[2], logSize[3]}, 32'b00_11_10_01);
    for (int i = 0; i < 4; i++)
      chk("R4", "narrow addr step", 32'(logAddr[i]), 32'h20 + 32'(i));
    chk("R5", "long narrow data, lower lane ignored", rd, exp);
  endtask

  task automatic testLongNarrowWrite();
    logic [31:0] rd;
    runOp(24'h000040, 2'b00, 1'b1, 32'hC3A17E29, 1'b0, 0, rd);
    chk("R6", "first write cycle lanes", 32'(logDout[0]), 32'hC3A1);
    chk("R6", "odd write cycle copies byte", 32'(logDout[1]), 32'hA1A1);
    chk("R6", "third write cycle lanes", 32'(logDout[2]), 32'h7E29);
    chk("R6", "last write cycle copies byte", 32'(logDout[3]), 32'h2929);
    chk("R4", "long narrow write memory", {mem[8'h40], mem[8'h41], mem[8'h42], mem[8'h43]}, 32'hC3A17E29);
  endtask

  task automatic testLongWide();
    logic [31:0] rd, exp;
    exp = {mem[8'h30], mem[8'h31], mem[8'h32], mem[8'h33]};
    runOp(24'h000030, 2'b00, 1'b0, '0, 1'b1, 0, rd);
    chk("R7", "long wide cycles", 32'(logCnt), 32'd2);
    chk("R7", "long wide sizes", {28'd0, logSize[0], logSize[1]}, 32'b0010);
    chk("R7", "long wide second addr", 32'(logAddr[1]), 32'h32);
    chk("R7", "long wide data", rd, exp);
  endtask

  task automatic testWideWriteWait();
    logic [31:0] rd;
    runOp(24'h000050, 2'b00, 1'b1, 32'h1234ABCD, 1'b1, 3, rd);
    chk("R9", "waits add no cycles", 32'(logCnt), 32'd2);
    chk("R9", "data held through waits", 32'(logDout[0]), 32'h1234);
    chk("R9", "addr held through waits", 32'(logAddr[0]), 32'h50);
    chk("R7", "wide write memory", {mem[8'h50], mem[8'h51], mem[8'h52], mem[8'h53]}, 32'h1234ABCD);
  endtask

  task automatic testByteOps();
    logic [31:0] rd, exp;
    exp = {24'h0, mem[8'h61]};
    runOp(24'h000061, 2'b01, 1'b0, '0, 1'b0, 0, rd);
    chk("R2", "byte size code", {30'd0, logSize[0]}, 32'h1);
    chk("R5", "narrow byte right-justified", rd, exp);
    exp = {24'h0, mem[8'h63]};
    runOp(24'h000063, 2'b01, 1'b0, '0, 1'b1, 0, rd);
    chk("R8", "wide odd byte from lower lane", rd, exp);
    exp = {24'h0, mem[8'h66]};
    runOp(24'h000066, 2'b01, 1'b0, '0, 1'b1, 0, rd);
    chk("R8", "wide even byte from upper lane", rd, exp);
    exp = {24'h0, mem[8'h64], 8'hEE};
    runOp(24'h000065, 2'b01, 1'b1, 32'h000000EE, 1'b1, 0, rd);
    chk("R8", "wide odd byte write", {16'h0, mem[8'h64], mem[8'h65]}, exp[31:0] & 32'h0000FFFF);
    exp = {16'h0, mem[8'h70], mem[8'h71]};
    runOp(24'h000070, 2'b10, 1'b0, '0, 1'b0, 0, rd);
    chk("R4", "word narrow sizes", {28'd0, logSize[0], logSize[1]}, 32'b1001);
    chk("R5", "word narrow data", rd, exp);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] rd, exp;
    logic [7:0]  keep;
    exp  = {mem[8'h80], mem[8'h81], mem[8'h82], mem[8'h83]};
    keep = mem[8'hF0];
    startReq(24'h000080, 2'b00, 1'b0, '0, 1'b0, 2);
    @(negedge clk);
    chk("R12", "reqReady low while busy", {31'd0, reqReady}, 32'd0);
    reqValid = 1'b1; reqAddr = 24'h0000F0; reqSize = 2'b01; reqWrite = 1'b1; reqWdata = 32'hFFFFFFFF;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(rd);
    chk("R11", "busy request adds no cycles", 32'(logCnt), 32'd4);
    chk("R11", "operand unaffected", rd, exp);
    chk("R11", "last addr unaffected", 32'(logAddr[3]), 32'h83);
    repeat (5) @(negedge clk);
    chk("R11", "no bus cycle after", {31'd0, busActive}, 32'd0);
    chk("R11", "no extra write", {24'd0, mem[8'hF0]}, {24'd0, keep});
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWordWide();
    testLongNarrowRead();
    testLongNarrowWrite();
    testLongWide();
    testWideWriteWait();
    testByteOps();
    testBusyIgnore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule